// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global shift register that records the outcomes of the most recent resolved branches. That history and the low-order bits of the branch address together select one saturating counter from a flat table. The top bit of the selected counter is the prediction. For each table row picked by the address there are 2^m counters, one for each possible history pattern, so the same branch can be predicted differently depending on how the branches before it went.

The prediction is combinational. A fetch stage presents `pred_pc` and reads `pred_taken` and `pred_hist` in the same cycle. It keeps the returned history value with the branch. When the branch resolves, it returns the address, the actual direction and that saved history on the update port. On the next clock edge the block adjusts exactly one counter and shifts the outcome into the global history. With `HIST_BITS` set to 0 the history disappears and the block becomes a plain table of per-address counters.

Top module: `corr_bp`

## Requirements
- R1: After synchronous reset, every counter holds the weakly-not-taken value 2^(n-1)-1 (binary 01 for n=2). Every address is therefore predicted not-taken, and `pred_hist` reads all zeros.
- R2: `pred_taken` is the most significant bit of the counter at flat index {pred_pc[IDX_BITS-1:0], history}, with the history in the low bits. It follows `pred_pc` in the same cycle without a clock edge.
- R3: An update increments the selected counter on taken and decrements it on not-taken. The counter saturates at 2^n-1 and at 0 and never wraps.
- R4: With n=2, a counter at strongly taken (11) keeps predicting taken after one not-taken update. It predicts not-taken only after a second one. The symmetric rule holds from strongly not-taken.
- R5: Each valid update shifts the global history left by one. The new outcome enters at bit 0 (1 = taken, 0 = not-taken) and the oldest bit drops out. The history is visible on `pred_hist`.
- R6: An update changes only the counter at index {upd_pc[IDX_BITS-1:0], upd_hist}. All other counters keep their values.
- R7: No tag is stored. Addresses that agree in bits IDX_BITS-1:0 share the same counters.
- R8: When a prediction and an update occur in the same cycle, the prediction reflects the state from before that update.
- R9: With HIST_BITS=0, the index is pred_pc[IDX_BITS-1:0] alone. `upd_hist` is ignored and `pred_hist` stays 0, which makes the block a plain per-address n-bit counter table.
- R10: While `upd_valid` is low, the values on `upd_pc`, `upd_taken` and `upd_hist` change neither the counters nor the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_BITS | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_BITS,1) | Global history used for this prediction |
| upd_valid | input | 1 | Update port carries a resolved branch |
| upd_pc | input | PC_BITS | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction, 1 = taken |
| upd_hist | input | max(HIST_BITS,1) | History value returned with the earlier prediction |

## Verification
The checker watches the global history on every clock. It confirms that a valid update shifts the outcome into bit 0, that the history holds while no update arrives, and that it is cleared by reset. It also checks that a prediction for an unchanged address stays unchanged across a cycle with no update. For the history-free variant, it checks that a taken update to a predicted-taken address keeps that prediction.

The counter-level behaviour can only be shown by the bench comparing against its own table model. This covers saturation at both ends, the two-step flip, aliasing of high address bits, isolation of one counter from its neighbours, and the pre-update value seen by a prediction made in the same cycle as an update.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Widest counter the step function supports
    localparam int unsigned CTR_MAX_W = 8;

    // Saturating up/down step of an n-bit counter held in a CTR_MAX_W container
    function automatic logic [CTR_MAX_W-1:0] ctr_step(
        input logic [CTR_MAX_W-1:0] cur,
        input logic                 taken,
        input int unsigned          bits
    );
        logic [CTR_MAX_W-1:0] top;
        top = CTR_MAX_W'((32'd1 << bits) - 32'd1);
        if (taken)
            return (cur == top) ? cur : cur + 1'b1;
        else
            return (cur == '0) ? cur : cur - 1'b1;
    endfunction

    // Reset value: the weak side of not-taken
    function automatic logic [CTR_MAX_W-1:0] ctr_init(input int unsigned bits);
        return CTR_MAX_W'((32'd1 << (bits - 1)) - 32'd1);
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned HIST_W    = (HIST_BITS == 0) ? 1 : HIST_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              taken_in,
    output logic [HIST_W-1:0] hist_o
);

    generate
        if (HIST_BITS == 0) begin : g_none
            logic unused_hist_in;
            assign unused_hist_in = ^{clk, rst, shift_en, taken_in};
            assign hist_o = '0;
        end else if (HIST_BITS == 1) begin : g_one
            logic ghr_q;
            always_ff @(posedge clk) begin
                if (rst)
                    ghr_q <= 1'b0;
                else if (shift_en)
                    ghr_q <= taken_in;
            end
            assign hist_o = ghr_q;
        end else begin : g_multi
            logic [HIST_BITS-1:0] ghr_q;
            always_ff @(posedge clk) begin
                if (rst)
                    ghr_q <= '0;
                else if (shift_en)
                    ghr_q <= {ghr_q[HIST_BITS-2:0], taken_in};
            end
            assign hist_o = ghr_q;
        end
    endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index #(
    parameter int unsigned IDX_BITS  = 10,
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned HIST_W    = (HIST_BITS == 0) ? 1 : HIST_BITS,
    parameter int unsigned ADDR_W    = IDX_BITS + HIST_BITS
) (
    input  logic [IDX_BITS-1:0] pc_low,
    input  logic [HIST_W-1:0]   hist,
    output logic [ADDR_W-1:0]   addr
);

    generate
        if (HIST_BITS == 0) begin : g_addr_only
            logic unused_idx_hist;
            assign unused_idx_hist = ^hist;
            assign addr = pc_low;
        end else begin : g_concat
            assign addr = {pc_low, hist[HIST_BITS-1:0]};
        end
    endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DEPTH    = 4096,
    parameter int unsigned CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_taken
);

    localparam logic [CTR_BITS-1:0] INIT_VAL = CTR_BITS'(ctr_init(CTR_BITS));

    logic [CTR_BITS-1:0] ctr_mem [DEPTH];
    logic [CTR_BITS-1:0] wr_cur;
    logic [CTR_BITS-1:0] wr_next;

    always_comb begin
        wr_cur  = ctr_mem[wr_addr];
        wr_next = CTR_BITS'(ctr_step(CTR_MAX_W'(wr_cur), wr_taken, CTR_BITS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_mem[i] <= INIT_VAL;
        end else if (wr_en) begin
            ctr_mem[wr_addr] <= wr_next;
        end
    end

    // Read sees the array before any write at the coming edge
    assign rd_ctr = ctr_mem[rd_addr];

endmodule

// File: rtl/corr_bp.sv
module corr_bp
    import bp_pkg::*;
#(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned CTR_BITS  = 2,
    parameter int unsigned ENTRIES   = 1024,
    parameter int unsigned PC_BITS   = 32,
    localparam int unsigned HIST_W   = (HIST_BITS == 0) ? 1 : HIST_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PC_BITS-1:0] pred_pc,
    output logic               pred_taken,
    output logic [HIST_W-1:0]  pred_hist,
    input  logic               upd_valid,
    input  logic [PC_BITS-1:0] upd_pc,
    input  logic               upd_taken,
    input  logic [HIST_W-1:0]  upd_hist
);

    localparam int unsigned IDX_BITS = $clog2(ENTRIES);
    localparam int unsigned ADDR_W   = IDX_BITS + HIST_BITS;
    localparam int unsigned DEPTH    = ENTRIES << HIST_BITS;

    logic [HIST_W-1:0]   ghist;
    logic [ADDR_W-1:0]   rd_addr;
    logic [ADDR_W-1:0]   wr_addr;
    logic [CTR_BITS-1:0] rd_ctr;

    generate
        if (PC_BITS > IDX_BITS) begin : g_pc_hi
            logic unused_pc_hi;
            assign unused_pc_hi = ^{pred_pc[PC_BITS-1:IDX_BITS], upd_pc[PC_BITS-1:IDX_BITS]};
        end
    endgenerate

    bp_history #(
        .HIST_BITS (HIST_BITS),
        .HIST_W    (HIST_W)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .taken_in (upd_taken),
        .hist_o   (ghist)
    );

    bp_index #(
        .IDX_BITS  (IDX_BITS),
        .HIST_BITS (HIST_BITS),
        .HIST_W    (HIST_W),
        .ADDR_W    (ADDR_W)
    ) u_rd_idx (
        .pc_low (pred_pc[IDX_BITS-1:0]),
        .hist   (ghist),
        .addr   (rd_addr)
    );

    bp_index #(
        .IDX_BITS  (IDX_BITS),
        .HIST_BITS (HIST_BITS),
        .HIST_W    (HIST_W),
        .ADDR_W    (ADDR_W)
    ) u_wr_idx (
        .pc_low (upd_pc[IDX_BITS-1:0]),
        .hist   (upd_hist),
        .addr   (wr_addr)
    );

    bp_ctr_table #(
        .ADDR_W   (ADDR_W),
        .DEPTH    (DEPTH),
        .CTR_BITS (CTR_BITS)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (rd_addr),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_addr  (wr_addr),
        .wr_taken (upd_taken)
    );

    assign pred_taken = rd_ctr[CTR_BITS-1];
    assign pred_hist  = ghist;

endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk #(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned ENTRIES   = 1024,
    parameter int unsigned PC_BITS   = 32,
    localparam int unsigned HIST_W   = (HIST_BITS == 0) ? 1 : HIST_BITS,
    localparam int unsigned IDX_BITS = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_BITS-1:0] pred_pc,
    input logic               pred_taken,
    input logic [HIST_W-1:0]  pred_hist,
    input logic               upd_valid,
    input logic [PC_BITS-1:0] upd_pc,
    input logic               upd_taken,
    input logic [HIST_W-1:0]  upd_hist
);

    logic unused_chk;
    assign unused_chk = ^{upd_pc, upd_hist};

    // R1: history cleared by reset
    assert_hist_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (pred_hist == '0));

    // R10: no update, no history movement
    assert_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(pred_hist));

    // R10: no update and same address gives the same prediction
    assert_pred_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ($stable(pred_pc) -> $stable(pred_taken)));

    generate
        if (HIST_BITS >= 2) begin : g_shift_multi
            // R5: outcome enters at bit 0, older bits move up
            assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> (pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}));
        end else if (HIST_BITS == 1) begin : g_shift_one
            assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> (pred_hist == $past(upd_taken)));
        end else begin : g_flat
            // R9: plain table keeps a zero history
            assert_flat_hist_R9: assert property (@(posedge clk) disable iff (rst)
                pred_hist == '0);
            // R4: a taken update never turns a taken prediction to not-taken
            assert_taken_keeps_R4: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && upd_taken && pred_taken &&
                 upd_pc[IDX_BITS-1:0] == pred_pc[IDX_BITS-1:0])
                |=> ($stable(pred_pc) -> pred_taken));
        end
    endgenerate

endmodule

bind corr_bp corr_bp_chk #(
    .HIST_BITS (HIST_BITS),
    .ENTRIES   (ENTRIES),
    .PC_BITS   (PC_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist)
);

// File: tb/test_corr_bp.sv
`timescale 1ns/1ps
module test_corr_bp;

    localparam int ENT = 16;
    localparam int PCW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [PCW-1:0] pred_pc = '0;
    logic           upd_valid = 1'b0;
    logic [PCW-1:0] upd_pc = '0;
    logic           upd_taken = 1'b0;
    logic [1:0]     upd_hist = '0;
    logic [0:0]     upd_hist_f = '0;

    logic           pred_taken, pred_taken_f;
    logic [1:0]     pred_hist;
    logic [0:0]     pred_hist_f;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    int ctr_m [ENT][4];
    int ctr_f [ENT];
    int hist_m;

    always #4 clk = ~clk;

    corr_bp #(.HIST_BITS(2), .CTR_BITS(2), .ENTRIES(ENT), .PC_BITS(PCW)) i_corr_bp (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist));

    corr_bp #(.HIST_BITS(0), .CTR_BITS(2), .ENTRIES(ENT), .PC_BITS(PCW)) i_corr_bp_flat (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken_f),
        .pred_hist(pred_hist_f), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist_f));

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sat(input int c, input logic t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic step(input logic [PCW-1:0] pc, input logic v, input logic [PCW-1:0] upc,
                        input logic t, input logic hf, input string tag);
        int pi, ui;
        @(negedge clk);
        pred_pc    = pc;
        upd_valid  = v;
        upd_pc     = upc;
        upd_taken  = t;
        upd_hist   = 2'(hist_m);
        upd_hist_f = hf;
        #1;
        pi = int'(pc) % ENT;
        // prediction sees pre-update state (R8), index is pc low bits + history (R2)
        check(int'(pred_taken), (ctr_m[pi][hist_m] >= 2) ? 1 : 0, tag, "main prediction");
        check(int'(pred_hist), hist_m, tag, "history R5");
        check(int'(pred_taken_f), (ctr_f[pi] >= 2) ? 1 : 0, tag, "flat prediction R9");
        check(int'(pred_hist_f), 0, tag, "flat history R9");
        @(posedge clk);
        #1;
        if (v) begin
            ui = int'(upc) % ENT;
            ctr_m[ui][hist_m] = sat(ctr_m[ui][hist_m], t);
            ctr_f[ui] = sat(ctr_f[ui], t);
            hist_m = ((hist_m << 1) | int'(t)) & 3;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < ENT; i++) begin
            ctr_f[i] = 1;
            for (int h = 0; h < 4; h++) ctr_m[i][h] = 1;
        end
        hist_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all addresses predict not-taken
        for (int p = 0; p < ENT; p++)
            step(8'(p), 1'b0, 8'(p), 1'b1, 1'b1, "R1");

        // R10: update inputs toggle while valid is low
        for (int p = 0; p < 8; p++)
            step(8'(p), 1'b0, 8'(p), p[0], p[1], "R10");

        // R4: hysteresis on flat table, address 3
        for (int k = 0; k < 3; k++) step(8'd3, 1'b1, 8'd3, 1'b1, 1'b1, "R4");
        step(8'd3, 1'b1, 8'd3, 1'b0, 1'b0, "R4");
        step(8'd3, 1'b1, 8'd3, 1'b0, 1'b1, "R4");
        step(8'd3, 1'b0, 8'd3, 1'b0, 1'b0, "R4");
        check(int'(pred_taken_f), 0, "R4", "flat flips after two misses");

        // R3: saturation at top then one decrement
        for (int k = 0; k < 6; k++) step(8'd9, 1'b1, 8'd9, 1'b1, 1'b0, "R3");
        step(8'd9, 1'b1, 8'd9, 1'b0, 1'b0, "R3");
        step(8'd9, 1'b0, 8'd9, 1'b0, 1'b0, "R3");
        check(int'(pred_taken_f), 1, "R3", "flat stays taken after saturate");
        // saturation at bottom
        for (int k = 0; k < 5; k++) step(8'd10, 1'b1, 8'd10, 1'b0, 1'b1, "R3");
        step(8'd10, 1'b1, 8'd10, 1'b1, 1'b1, "R3");
        step(8'd10, 1'b0, 8'd10, 1'b0, 1'b0, "R3");
        check(int'(pred_taken_f), 0, "R3", "flat stays not-taken after floor");

        // R7: aliasing of high address bits
        step(8'd5, 1'b1, 8'd5, 1'b1, 1'b0, "R7");
        step(8'd5, 1'b1, 8'd5, 1'b1, 1'b0, "R7");
        step(8'd5 + 8'd16, 1'b0, 8'd0, 1'b0, 1'b0, "R7");
        step(8'd5 + 8'd64, 1'b1, 8'd5 + 8'd128, 1'b1, 1'b0, "R7");

        // R8: predict and update the same address in one cycle
        for (int k = 0; k < 6; k++) step(8'd12, 1'b1, 8'd12, 1'b1, 1'b0, "R8");

        // R2 R5 R6: pseudo-random sweep compared with the table model
        lfsr = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            logic [PCW-1:0] pc, upc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc  = lfsr[7:0];
            upc = lfsr[9] ? pc : {lfsr[3:0], lfsr[15:12]};
            step(pc, lfsr[10] | lfsr[11], upc, lfsr[12] ^ lfsr[2], lfsr[5], "R2 R5 R6");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule